// File: doc/BRIEF.md
# Instruction Pointer Sequencer

This block is the next-address logic of a small processor that keeps code, data and stack in separate memories. It holds the 16-bit instruction pointer, which is the code fetch address, and one return-pointer register. Each time the decoder presents a valid instruction, the block picks the next fetch address from one of four sources. The first is a sequential step by the instruction length, which is 2, 3 or 4 bytes, each with a one-byte opcode in front. The others are an absolute jump target, a subroutine call target, and the saved return address.

The decoder supplies an instruction class, the length, two candidate targets and a selector between them. The immediate target comes from the instruction itself and the register target comes from a register-file read. The zero and carry flags left by the latest compare also arrive from outside and decide the four conditional jumps. A halt instruction freezes the pointer until the next reset.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the first instruction may be presented from the third rising edge after release.

Top module: `ip_sequencer`

## Requirements
- R1: While reset is held and after it is released, `fetch_addr` reads 0x0000 and `halted` reads 0.
- R2: A valid instruction of class 0 (step, also used for no-op) or of an unlisted class (9 to 15) moves `fetch_addr` to its old value plus `insn_len`, on the next rising edge.
- R3: Sequential address arithmetic wraps modulo 2^16. For example, 0xFFFE plus 4 gives 0x0002.
- R4: Class 1 (jump) loads `fetch_addr` with `reg_target` when `target_is_reg` is 1, and with `imm_target` when it is 0.
- R5: Class 2 (jump if above) takes the selected target only when `flag_carry` is 0 and `flag_zero` is 0.
- R6: Class 3 (jump if below or equal) takes the selected target when `flag_carry` is 1 or `flag_zero` is 1.
- R7: Class 4 (jump if equal) is taken when `flag_zero` is 1. Class 5 (jump if not equal) is taken when `flag_zero` is 0.
- R8: A conditional jump that is not taken advances `fetch_addr` by `insn_len`, the same as a step.
- R9: Class 6 (call) stores the old `fetch_addr` plus `insn_len` as the return address and jumps to the selected target. A later call overwrites the stored return address.
- R10: Class 7 (return) loads `fetch_addr` with the most recently stored return address.
- R11: Class 8 (halt) sets `halted` on the next edge and leaves `fetch_addr` unchanged. After that, no instruction of any class changes `fetch_addr`, `halted` or the return address until reset.
- R12: While `insn_valid` is 0, `fetch_addr` holds its value whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| insn_valid | input | 1 | A decoded instruction is present this cycle |
| insn_cls | input | 4 | Instruction class: 0 step, 1 jump, 2 above, 3 below-or-equal, 4 equal, 5 not-equal, 6 call, 7 return, 8 halt |
| insn_len | input | 3 | Instruction length in bytes (2 to 4) |
| target_is_reg | input | 1 | 1 selects `reg_target`, 0 selects `imm_target` |
| imm_target | input | 16 | Absolute target taken from the instruction |
| reg_target | input | 16 | Absolute target read from a register |
| flag_zero | input | 1 | Stored zero flag from the latest compare |
| flag_carry | input | 1 | Stored carry flag from the latest compare |
| fetch_addr | output | 16 | Current instruction pointer (code fetch address) |
| halted | output | 1 | The sequencer has executed a halt |

## Verification
Every internal state shows up at `fetch_addr` one edge after the instruction that uses it, except the return pointer. A wrong instruction pointer or a wrong flag decision appears at the very next sample. A corrupted or stale return address stays hidden until a return executes, so the bench runs a step between a call and its return, and places a second call before the return to expose an overwrite fault. A halt latch that leaks is exposed by offering jumps, calls and returns after the halt and checking that the address stays fixed.

// File: rtl/ipseq_pkg.sv
package ipseq_pkg;

  // Decoded instruction classes seen by the sequencer
  typedef enum logic [3:0] {
    CLS_STEP   = 4'd0,
    CLS_JUMP   = 4'd1,
    CLS_JABOVE = 4'd2,
    CLS_JBELEQ = 4'd3,
    CLS_JEQ    = 4'd4,
    CLS_JNE    = 4'd5,
    CLS_CALL   = 4'd6,
    CLS_RET    = 4'd7,
    CLS_HALT   = 4'd8
  } insn_cls_e;

  localparam int unsigned CLS_W = 4;

endpackage

// File: rtl/ipseq_rst_sync.sv
module ipseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ipseq_cond.sv
module ipseq_cond
  import ipseq_pkg::*;
(
  input  insn_cls_e cls,
  input  logic      flag_zero,
  input  logic      flag_carry,
  output logic      redirect
);

  // redirect: the selected target replaces the sequential address
  always_comb begin
    case (cls)
      CLS_JUMP,
      CLS_CALL:   redirect = 1'b1;
      CLS_JABOVE: redirect = !flag_carry && !flag_zero;
      CLS_JBELEQ: redirect = flag_carry || flag_zero;
      CLS_JEQ:    redirect = flag_zero;
      CLS_JNE:    redirect = !flag_zero;
      default:    redirect = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipseq_next.sv
module ipseq_next
  import ipseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 3
) (
  input  logic              insn_valid,
  input  insn_cls_e         cls,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [ADDR_W-1:0] target,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] ip_q,
  input  logic [ADDR_W-1:0] rp_q,
  input  logic              halted_q,
  output logic [ADDR_W-1:0] ip_d,
  output logic              ip_we,
  output logic [ADDR_W-1:0] rp_d,
  output logic              rp_we,
  output logic              halt_we
);

  localparam int unsigned PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] len_ext;
  logic [ADDR_W-1:0] seq_addr;
  logic              live;

  assign len_ext  = {{PAD_W{1'b0}}, insn_len};
  assign seq_addr = ip_q + len_ext;
  assign live     = insn_valid && !halted_q;

  always_comb begin
    ip_d    = seq_addr;
    ip_we   = 1'b0;
    rp_d    = seq_addr;
    rp_we   = 1'b0;
    halt_we = 1'b0;
    if (live) begin
      case (cls)
        CLS_RET: begin
          ip_d  = rp_q;
          ip_we = 1'b1;
        end
        CLS_HALT: begin
          halt_we = 1'b1;
        end
        CLS_CALL: begin
          ip_d  = target;
          ip_we = 1'b1;
          rp_we = 1'b1;
        end
        default: begin
          ip_d  = redirect ? target : seq_addr;
          ip_we = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/ipseq_regs.sv
module ipseq_regs #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ip_d,
  input  logic              ip_we,
  input  logic [ADDR_W-1:0] rp_d,
  input  logic              rp_we,
  input  logic              halt_we,
  output logic [ADDR_W-1:0] ip_q,
  output logic [ADDR_W-1:0] rp_q,
  output logic              halted_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= RESET_IP;
    else if (ip_we) ip_q <= ip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rp_q <= '0;
    else if (rp_we) rp_q <= rp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halted_q <= 1'b0;
    else if (halt_we) halted_q <= 1'b1;
  end

endmodule

// File: rtl/ip_sequencer.sv
module ip_sequencer
  import ipseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned LEN_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [CLS_W-1:0]  insn_cls,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic              target_is_reg,
  input  logic [ADDR_W-1:0] imm_target,
  input  logic [ADDR_W-1:0] reg_target,
  input  logic              flag_zero,
  input  logic              flag_carry,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] RESET_IP = '0;

  logic              rst_sync_n;
  insn_cls_e         cls;
  logic [ADDR_W-1:0] target;
  logic              redirect;
  logic [ADDR_W-1:0] ip_q, rp_q, ip_d, rp_d;
  logic              halted_q;
  logic              ip_we, rp_we, halt_we;

  assign cls    = insn_cls_e'(insn_cls);
  assign target = target_is_reg ? reg_target : imm_target;

  ipseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipseq_cond u_cond (
    .cls        (cls),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .redirect   (redirect)
  );

  ipseq_next #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next (
    .insn_valid (insn_valid),
    .cls        (cls),
    .insn_len   (insn_len),
    .target     (target),
    .redirect   (redirect),
    .ip_q       (ip_q),
    .rp_q       (rp_q),
    .halted_q   (halted_q),
    .ip_d       (ip_d),
    .ip_we      (ip_we),
    .rp_d       (rp_d),
    .rp_we      (rp_we),
    .halt_we    (halt_we)
  );

  ipseq_regs #(.ADDR_W(ADDR_W), .RESET_IP(RESET_IP)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ip_d     (ip_d),
    .ip_we    (ip_we),
    .rp_d     (rp_d),
    .rp_we    (rp_we),
    .halt_we  (halt_we),
    .ip_q     (ip_q),
    .rp_q     (rp_q),
    .halted_q (halted_q)
  );

  assign fetch_addr = ip_q;
  assign halted     = halted_q;

endmodule

// File: rtl/ip_sequencer_chk.sv
module ip_sequencer_chk
  import ipseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              insn_valid,
  input logic [CLS_W-1:0]  insn_cls,
  input logic [LEN_W-1:0]  insn_len,
  input logic              target_is_reg,
  input logic [ADDR_W-1:0] imm_target,
  input logic [ADDR_W-1:0] reg_target,
  input logic              flag_zero,
  input logic [ADDR_W-1:0] rp_q,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              halted
);

  logic live;
  assign live = insn_valid && !halted;

  // R1: first cycle out of reset starts at address zero, not halted
  assert_reset_start_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (fetch_addr == '0 && !halted));

  // R2: a step advances by the instruction length
  assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && insn_cls == CLS_STEP) |=>
      fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'($past(insn_len))));

  // R8: equal-jump with zero flag clear falls through
  assert_untaken_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && insn_cls == CLS_JEQ && !flag_zero) |=>
      fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'($past(insn_len))));

  // R9: call lands on the selected target
  assert_call_target_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && insn_cls == CLS_CALL) |=>
      fetch_addr == $past(target_is_reg ? reg_target : imm_target));

  // R10: return lands on the saved return address
  assert_ret_restore_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && insn_cls == CLS_RET) |=> fetch_addr == $past(rp_q));

  // R11: once halted, address, flag and return pointer are frozen
  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |=> (halted && $stable(fetch_addr) && $stable(rp_q)));

  // R12: no valid instruction, no movement
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !insn_valid |=> $stable(fetch_addr));

endmodule

bind ip_sequencer ip_sequencer_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .insn_valid    (insn_valid),
  .insn_cls      (insn_cls),
  .insn_len      (insn_len),
  .target_is_reg (target_is_reg),
  .imm_target    (imm_target),
  .reg_target    (reg_target),
  .flag_zero     (flag_zero),
  .rp_q          (rp_q),
  .fetch_addr    (fetch_addr),
  .halted        (halted)
);

// File: tb/ip_sequencer_bench.sv
module ip_sequencer_bench;
  import ipseq_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        insn_valid;
  logic [3:0]  insn_cls;
  logic [2:0]  insn_len;
  logic        target_is_reg;
  logic [15:0] imm_target;
  logic [15:0] reg_target;
  logic        flag_zero;
  logic        flag_carry;
  logic [15:0] fetch_addr;
  logic        halted;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_ip;
  logic [15:0] exp_rp;

  ip_sequencer u_ip_sequencer (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid    (insn_valid),
    .insn_cls      (insn_cls),
    .insn_len      (insn_len),
    .target_is_reg (target_is_reg),
    .imm_target    (imm_target),
    .reg_target    (reg_target),
    .flag_zero     (flag_zero),
    .flag_carry    (flag_carry),
    .fetch_addr    (fetch_addr),
    .halted        (halted)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, expv);
    end
  endtask

  // Present one instruction for one edge; returns at the following negedge
  task automatic issue(logic [3:0] cls, int len, bit treg, logic [15:0] imm,
                       logic [15:0] rg, bit z, bit c);
    insn_cls      = cls;
    insn_len      = 3'(len);
    target_is_reg = treg;
    imm_target    = imm;
    reg_target    = rg;
    flag_zero     = z;
    flag_carry    = c;
    insn_valid    = 1'b1;
    @(negedge clk);
    insn_valid    = 1'b0;
  endtask

  task automatic do_reset();
    insn_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 addr in reset", fetch_addr, 16'h0000);
    check("R1 halted in reset", {15'd0, halted}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 addr after reset", fetch_addr, 16'h0000);
    check("R1 halted after reset", {15'd0, halted}, 16'h0000);
    exp_ip = 16'h0000;
    exp_rp = 16'h0000;
  endtask

  task automatic t_step();
    for (int l = 2; l <= 4; l++) begin
      issue(CLS_STEP, l, 1'b0, 16'hAAAA, 16'h5555, 1'b1, 1'b1);
      exp_ip = exp_ip + 16'(l);
      check("R2 step", fetch_addr, exp_ip);
    end
    issue(4'd11, 3, 1'b0, 16'h1234, 16'h4321, 1'b1, 1'b0);
    exp_ip = exp_ip + 16'd3;
    check("R2 unlisted class", fetch_addr, exp_ip);
  endtask

  task automatic t_idle();
    insn_cls = CLS_JUMP; imm_target = 16'hBEEF; reg_target = 16'hBEEF;
    insn_len = 3'd4; insn_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 idle hold", fetch_addr, exp_ip);
  endtask

  task automatic t_jump();
    issue(CLS_JUMP, 2, 1'b0, 16'h0200, 16'h0900, 1'b0, 1'b0);
    exp_ip = 16'h0200;
    check("R4 jump imm", fetch_addr, exp_ip);
    issue(CLS_JUMP, 2, 1'b1, 16'h0200, 16'h0900, 1'b0, 1'b0);
    exp_ip = 16'h0900;
    check("R4 jump reg", fetch_addr, exp_ip);
  endtask

  task automatic t_wrap();
    issue(CLS_JUMP, 2, 1'b0, 16'hFFFE, 16'h0000, 1'b0, 1'b0);
    issue(CLS_STEP, 4, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    exp_ip = 16'h0002;
    check("R3 wrap", fetch_addr, exp_ip);
  endtask

  function automatic bit bench_taken(logic [3:0] cls, bit z, bit c);
    case (cls)
      CLS_JABOVE: return !c && !z;
      CLS_JBELEQ: return c || z;
      CLS_JEQ:    return z;
      CLS_JNE:    return !z;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic t_cond(logic [3:0] cls, string req);
    for (int f = 0; f < 4; f++) begin
      bit z = f[0];
      bit c = f[1];
      bit treg = f[0] ^ f[1];
      logic [15:0] tgt = treg ? 16'h4400 + 16'(f) : 16'h3300 + 16'(f);
      issue(cls, 3, treg, 16'h3300 + 16'(f), 16'h4400 + 16'(f), z, c);
      if (bench_taken(cls, z, c)) begin
        exp_ip = tgt;
        check(req, fetch_addr, exp_ip);
      end else begin
        exp_ip = exp_ip + 16'd3;
        check({req, " R8 untaken"}, fetch_addr, exp_ip);
      end
    end
  endtask

  task automatic t_call_ret();
    issue(CLS_JUMP, 2, 1'b0, 16'h0100, 16'h0000, 1'b0, 1'b0);
    issue(CLS_CALL, 3, 1'b0, 16'h2000, 16'h7777, 1'b0, 1'b0);
    exp_rp = 16'h0103; exp_ip = 16'h2000;
    check("R9 call target", fetch_addr, exp_ip);
    issue(CLS_STEP, 2, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    exp_ip = 16'h2002;
    issue(CLS_CALL, 4, 1'b1, 16'h6666, 16'h3000, 1'b1, 1'b0);
    exp_rp = 16'h2006; exp_ip = 16'h3000;
    check("R9 nested call target", fetch_addr, exp_ip);
    issue(CLS_RET, 2, 1'b0, 16'h1111, 16'h2222, 1'b0, 1'b0);
    exp_ip = exp_rp;
    check("R10 return after nested call (R9 overwrite)", fetch_addr, exp_ip);
  endtask

  task automatic t_halt();
    issue(CLS_CALL, 2, 1'b0, 16'h5000, 16'h0000, 1'b0, 1'b0);
    exp_rp = exp_ip + 16'd2; exp_ip = 16'h5000;
    issue(CLS_HALT, 2, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R11 halt addr", fetch_addr, exp_ip);
    check("R11 halted set", {15'd0, halted}, 16'h0001);
    issue(CLS_JUMP, 2, 1'b0, 16'h0ABC, 16'h0ABC, 1'b0, 1'b0);
    check("R11 jump ignored", fetch_addr, exp_ip);
    issue(CLS_CALL, 2, 1'b0, 16'h0DEF, 16'h0DEF, 1'b0, 1'b0);
    check("R11 call ignored", fetch_addr, exp_ip);
    issue(CLS_RET, 2, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R11 ret ignored", fetch_addr, exp_ip);
    issue(CLS_STEP, 4, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R11 step ignored", fetch_addr, exp_ip);
    check("R11 still halted", {15'd0, halted}, 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0;
    insn_valid = 1'b0; insn_cls = '0; insn_len = 3'd2; target_is_reg = 1'b0;
    imm_target = '0; reg_target = '0; flag_zero = 1'b0; flag_carry = 1'b0;
    @(negedge clk);
    do_reset();
    t_step();
    t_idle();
    t_jump();
    t_wrap();
    t_cond(CLS_JABOVE, "R5 above");
    t_cond(CLS_JBELEQ, "R6 below-or-equal");
    t_cond(CLS_JEQ,    "R7 equal");
    t_cond(CLS_JNE,    "R7 not-equal");
    t_call_ret();
    t_halt();
    do_reset();
    t_step();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule